// File: doc/BRIEF.md
# General-Purpose I/O Bank with Pin Interrupts

This block is one bank of general-purpose pins behind a small memory-mapped register port. For each pin, software chooses whether the pin is an output and, separately, whether its driver is switched on. It writes output values, which land only on pins already set as outputs. It can read back the level of every pin in the bank. Inputs pass through a synchroniser. On each pin, a detector watches for a level, for a single edge, or for both edges.

Detected events set sticky per-pin pending flags, and software clears them by writing ones. A per-pin mask, changed by write-one enable and disable strobes, gates those flags into a single interrupt line. The bus is a plain strobe port. A write takes effect at the clock edge where it is presented. Read data is registered and is valid one cycle after the read strobe.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, direction, output-enable and data registers are zero, pin_oe and pin_o are zero, the mask register reads all ones, pending status reads zero, irq is 0, the type register reads all ones (edge), and polarity and any-edge registers read zero.
- R2: pin_oe[i] is 1 exactly when both the direction bit and the output-enable bit of pin i are 1; pin_o carries the data register.
- R3: A write to the data register (byte offset 0x00) updates only those bits whose direction bit is already 1; the other bits keep their value, visible on pin_o.
- R4: A data-register read returns, per pin, the data register bit when its direction bit is 1 and the synchronised input level otherwise; a pin_i change is visible to a read issued two cycles after it.
- R5: Byte offsets: 0x00 data, 0x04 direction, 0x08 output enable, 0x0C type, 0x10 polarity, 0x14 any-edge (all read back as written), 0x18 enable strobe and 0x1C disable strobe (both read 0), 0x20 mask (read-only), 0x24 pending status; any other offset reads 0; read data appears on bus_rdata in the cycle after bus_rd.
- R6: With type bit 0 (level), a pin whose synchronised level equals its polarity bit (1 high, 0 low) sets its pending bit on every cycle, so a clear written while the level holds leaves the bit set; once the level is gone a clear removes it.
- R7: With type bit 1 (edge) and any-edge 0, polarity 1 detects rising and polarity 0 detects falling edges only; the pending bit then stays set until cleared.
- R8: With type bit 1 and any-edge bit 1, both rising and falling edges set the pending bit, whatever the polarity.
- R9: Writing ones to the enable strobe clears those mask bits, writing ones to the disable strobe sets them; zero bits leave the mask unchanged.
- R10: Writing ones to the status offset clears those pending bits; zero bits leave them; an event in the same cycle as its clear wins.
- R11: irq is 1 exactly when some pin has a pending bit and a mask bit of 0; pending bits are set even on masked pins.
- R12: A pin_i change at an edge-detecting or level-detecting pin sets the pending bit (and irq, if unmasked) at the third rising clock edge after the change, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_i | input | 32 | Pin input levels (asynchronous) |
| pin_o | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin driver enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 pins and a two-stage synchroniser. So the exact three-edge latency from a pin change to a pending flag can be checked cycle by cycle. The full 32-bit width lets one data vector mix output and input halves. That shows writes being dropped on input pins, and shows reads merging driven values with sampled levels. Separate pins carry level, rising, falling and any-edge detection side by side. This exposes cross-talk between the per-pin mode bits.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank: bus width and register word indices.
// Assumes word-aligned registers; byte offset = index * 4.
package gpio_bank_pkg;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = ADDR_W - 2;

    typedef enum logic [IDX_W-1:0] {
        RG_DATA = 4'd0,
        RG_DIR  = 4'd1,
        RG_OE   = 4'd2,
        RG_TYPE = 4'd3,
        RG_POL  = 4'd4,
        RG_ANY  = 4'd5,
        RG_IEN  = 4'd6,
        RG_IDIS = 4'd7,
        RG_MASK = 4'd8,
        RG_STAT = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is provided.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
// Per-pin event detector and pending flag.
// Assumes smp is already synchronous. Level mode sets the flag each cycle
// the condition holds; edge mode compares against the previous sample.
// A set in the same cycle as a clear wins.
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic edge_mode,
    input  logic pol_high,
    input  logic both_edges,
    input  logic clr,
    output logic ev,
    output logic pend
);
    logic prev_q;
    logic rise, fall;

    // Remember the last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp;
    end

    // Select the event condition for the configured mode.
    always_comb begin
        rise = smp & ~prev_q;
        fall = ~smp & prev_q;
        if (!edge_mode)      ev = pol_high ? smp : ~smp;
        else if (both_edges) ev = rise | fall;
        else                 ev = pol_high ? rise : fall;
    end

    // Hold the pending flag until a write-one clear without a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~clr) | ev;
    end
endmodule

// File: rtl/gpio_bank_irq.sv
// GPIO bank: register port, output drive, input sampling and interrupts.
// Assumes one access per cycle; writes commit at the strobe edge, reads are
// registered and valid the next cycle. Low address bits [1:0] are ignored.
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [IDX_W-1:0] idx;
    logic [NPINS-1:0] dir_q, oe_q, data_q, type_q, pol_q, any_q, mask_q;
    logic [NPINS-1:0] sync_q, irq_status, irq_event, stat_clr, pin_lvl;
    logic [NPINS-1:0] rd_mux, rdata_q;

    assign idx = bus_addr[ADDR_W-1:2];

    gpio_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_q)
    );

    // Write-one clear vector for the pending flags.
    always_comb begin
        stat_clr = '0;
        if (bus_wr && idx == RG_STAT) stat_clr = bus_wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_pin
            gpio_irq_cell u_cell (
                .clk(clk), .rst_n(rst_n), .smp(sync_q[gi]),
                .edge_mode(type_q[gi]), .pol_high(pol_q[gi]),
                .both_edges(any_q[gi]), .clr(stat_clr[gi]),
                .ev(irq_event[gi]), .pend(irq_status[gi])
            );
        end
    endgenerate

    // Configuration and mask registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            oe_q   <= '0;
            data_q <= '0;
            type_q <= '1;
            pol_q  <= '0;
            any_q  <= '0;
            mask_q <= '1;
        end else if (bus_wr) begin
            case (idx)
                RG_DATA: data_q <= (data_q & ~dir_q) | (bus_wdata & dir_q);
                RG_DIR:  dir_q  <= bus_wdata;
                RG_OE:   oe_q   <= bus_wdata;
                RG_TYPE: type_q <= bus_wdata;
                RG_POL:  pol_q  <= bus_wdata;
                RG_ANY:  any_q  <= bus_wdata;
                RG_IEN:  mask_q <= mask_q & ~bus_wdata;
                RG_IDIS: mask_q <= mask_q | bus_wdata;
                default: ;
            endcase
        end
    end

    assign pin_lvl = (dir_q & data_q) | (~dir_q & sync_q);

    // Select the register addressed by a read.
    always_comb begin
        case (idx)
            RG_DATA: rd_mux = pin_lvl;
            RG_DIR:  rd_mux = dir_q;
            RG_OE:   rd_mux = oe_q;
            RG_TYPE: rd_mux = type_q;
            RG_POL:  rd_mux = pol_q;
            RG_ANY:  rd_mux = any_q;
            RG_MASK: rd_mux = mask_q;
            RG_STAT: rd_mux = irq_status;
            default: rd_mux = '0;
        endcase
    end

    // Register the read data for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pin_o     = data_q;
    assign pin_oe    = dir_q & oe_q;
    assign irq       = |(irq_status & ~mask_q);
endmodule

// File: rtl/gpio_bank_chk.sv
// Property checker for gpio_bank_irq, attached by bind.
// Assumes the internal register names of the top module.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [NPINS-1:0]  wdata,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  data_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  clr,
    input logic [NPINS-1:0]  ev
);
    logic [IDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    p_input_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_DATA) |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0));

    p_enable_unmasks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_IEN) |=> ((mask_q & $past(wdata)) == '0));

    p_disable_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_IDIS) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_STAT) |=> ((status & $past(wdata & ~ev)) == '0));

    p_pending_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr) & ~status) == '0));

    p_event_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(ev)) & ~status) == '0));
endmodule

bind gpio_bank_irq gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dir_q(dir_q), .data_q(data_q), .mask_q(mask_q), .status(irq_status),
    .clr(stat_clr), .ev(irq_event)
);

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pin_o, pin_oe;
    logic [31:0] pin_i = '0;
    logic        irq;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_OE = 6'h08,
        A_TYPE = 6'h0C, A_POL = 6'h10, A_ANY = 6'h14, A_IEN = 6'h18,
        A_IDIS = 6'h1C, A_MASK = 6'h20, A_STAT = 6'h24, A_NONE = 6'h28;

    // Columns: direction, write data, pin inputs, expected read, expected pin_o.
    localparam logic [31:0] VEC [4][5] = '{
        '{32'hFFFF0000, 32'h12345678, 32'h00000000, 32'h12340000, 32'h12340000},
        '{32'h0000FFFF, 32'hAAAAAAAA, 32'hF0F00000, 32'hF0F0AAAA, 32'h1234AAAA},
        '{32'hFFFFFFFF, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF, 32'hDEADBEEF},
        '{32'h00000000, 32'h00000000, 32'h0F0F0F0F, 32'h0F0F0F0F, 32'hDEADBEEF}
    };

    gpio_bank_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_o", pin_o, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rchk("R1 data", A_DATA, 32'h0);
        rchk("R1 dir", A_DIR, 32'h0);
        rchk("R1 oe", A_OE, 32'h0);
        rchk("R1 mask", A_MASK, 32'hFFFFFFFF);
        rchk("R1 status", A_STAT, 32'h0);
        rchk("R1 type", A_TYPE, 32'hFFFFFFFF);
        rchk("R1 pol", A_POL, 32'h0);
        rchk("R1 any", A_ANY, 32'h0);

        // R3/R4 table walk: masked data writes and merged reads
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pin_i = VEC[k][2];
            wr(A_DIR, VEC[k][0]);
            wr(A_DATA, VEC[k][1]);
            rchk("R4 data read", A_DATA, VEC[k][3]);
            chk("R3 pin_o", pin_o, VEC[k][4]);
        end

        // R2 driver enable needs both bits
        wr(A_OE, 32'hFF00FF00);
        chk("R2 oe without dir", pin_oe, 32'h0);
        wr(A_DIR, 32'hFFFF0000);
        chk("R2 oe and dir", pin_oe, 32'hFF000000);
        rchk("R5 oe readback", A_OE, 32'hFF00FF00);

        // Quiet the inputs and clear stale flags
        @(negedge clk);
        pin_i = '0;
        idle(5);
        wr(A_STAT, 32'hFFFFFFFF);
        rchk("R10 clear all", A_STAT, 32'h0);

        // Mode setup: pin0 level-high, pin1 rising, pin2 falling, pin3 any-edge
        wr(A_POL, 32'h0000000B);
        wr(A_ANY, 32'h00000008);
        wr(A_TYPE, 32'hFFFFFFFE);
        rchk("R5 type", A_TYPE, 32'hFFFFFFFE);
        rchk("R5 pol", A_POL, 32'h0000000B);
        rchk("R5 any", A_ANY, 32'h00000008);
        rchk("R5 unmapped", A_NONE, 32'h0);
        rchk("R6 no level yet", A_STAT, 32'h0);

        wr(A_IEN, 32'h00000001);
        rchk("R9 mask after enable", A_MASK, 32'hFFFFFFFE);
        rchk("R5 enable reads zero", A_IEN, 32'h0);

        // R12 latency, R6 level behaviour
        @(negedge clk);
        pin_i[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R12 not yet", {31'b0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R12 third edge", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h00000001);
        rchk("R6 clear while level holds", A_STAT, 32'h1);
        chk("R6 irq stays", {31'b0, irq}, 32'h1);
        @(negedge clk);
        pin_i[0] = 1'b0;
        idle(4);
        wr(A_STAT, 32'h00000001);
        rchk("R6 cleared after level gone", A_STAT, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);

        wr(A_IDIS, 32'h00000001);
        rchk("R9 mask after disable", A_MASK, 32'hFFFFFFFF);

        // R7 rising edge on pin1, masked first
        @(negedge clk);
        pin_i[1] = 1'b1;
        idle(4);
        rchk("R7 rising sets", A_STAT, 32'h2);
        chk("R11 masked no irq", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h00000002);
        chk("R11 unmask raises irq", {31'b0, irq}, 32'h1);
        rchk("R9 enable mask bit1", A_MASK, 32'hFFFFFFFD);
        @(negedge clk);
        pin_i[1] = 1'b0;
        idle(4);
        rchk("R7 sticky after fall", A_STAT, 32'h2);
        wr(A_STAT, 32'h00000000);
        rchk("R10 zeros keep", A_STAT, 32'h2);
        wr(A_STAT, 32'h00000002);
        rchk("R10 ones clear", A_STAT, 32'h0);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);

        // R7 falling edge on pin2
        @(negedge clk);
        pin_i[2] = 1'b1;
        idle(4);
        rchk("R7 rise ignored pol0", A_STAT, 32'h0);
        @(negedge clk);
        pin_i[2] = 1'b0;
        idle(4);
        rchk("R7 falling sets", A_STAT, 32'h4);
        wr(A_STAT, 32'h00000004);

        // R8 any-edge on pin3 with polarity 1
        @(negedge clk);
        pin_i[3] = 1'b1;
        idle(4);
        rchk("R8 rise sets", A_STAT, 32'h8);
        wr(A_STAT, 32'h00000008);
        rchk("R8 cleared", A_STAT, 32'h0);
        @(negedge clk);
        pin_i[3] = 1'b0;
        idle(4);
        rchk("R8 fall sets despite pol1", A_STAT, 32'h8);

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule